// File: doc/BRIEF.md
# Page Write Buffer and Program Sequencer

This block sits between the command front end of a serial EEPROM and its storage array. The front end opens a write with a start address. It then hands over the data bytes one at a time, and it closes the sequence when chip select returns high. The block keeps the bytes in a one-page staging buffer, and it records which byte positions were loaded. When the sequence is closed with at least one whole byte received, and the protection logic allows it, the block starts a self-timed programming cycle. During that cycle it copies only the loaded positions into the array, inside the page chosen by the start address.

Only the low byte index moves forward as bytes arrive. When it passes the end of the page it wraps to the first position of the same page, and a later byte replaces an earlier one. The programming cycle lasts a set number of system clocks. The count is one of two parameters, and a volatile fast-write flag picks between them when the cycle starts. While the cycle runs, the busy output stays high and all load and close requests are ignored. The cycle ends with a one-clock completion pulse, which the status logic also uses to clear its write enable latch. The array has a read port so that its contents can be observed.

Top module: `page_write_ctrl`

## Requirements
- R1: After synchronous reset, `busy` and `done` are both 0.
- R2: The n-th loaded byte (counting from 0) of a committed write lands at array address {start page, (start index + n) mod 256}, where the start page is `start_addr[ADDR_W-1:8]` and the start index is `start_addr[7:0]`.
- R3: When more than 256 bytes are loaded, the index wraps inside the same page, so each position holds the last byte loaded there, and no other page changes.
- R4: In the programmed page, positions that received no byte keep their previous contents.
- R5: A cycle starts, and `busy` rises one clock after `seq_end`, only when `seq_end` arrives during an open load with at least one byte received and `accept` = 1. Otherwise the sequence is dropped, `busy` stays 0, and the array is unchanged.
- R6: `busy` stays high for exactly `STD_CYCLES` clocks when `fast_mode` was 0 at `seq_end`, and for exactly `FAST_CYCLES` clocks when it was 1. Changing `fast_mode` during the cycle has no effect.
- R7: `done` is high for exactly one clock, the first clock in which `busy` is low again after a cycle, and it is never high at any other time.
- R8: While `busy` is high, `load_start`, `byte_strobe` and `seq_end` have no effect: no byte is stored and no further cycle follows.
- R9: `rd_data` shows the array byte at `rd_addr` one clock after `rd_addr` is applied, and all programmed bytes are visible there once `done` has pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| load_start | input | 1 | Opens a load and takes `start_addr` (ignored while busy) |
| start_addr | input | ADDR_W | Array byte address at which loading begins |
| byte_strobe | input | 1 | One data byte is present on `byte_data` |
| byte_data | input | DATA_W | Data byte to load |
| seq_end | input | 1 | Chip select has risen; closes the sequence |
| accept | input | 1 | Protection verdict, sampled with `seq_end` |
| fast_mode | input | 1 | Fast-write flag, sampled with `seq_end` |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | DATA_W | Array read data, one clock latency |
| busy | output | 1 | Programming cycle in progress |
| done | output | 1 | One-clock completion pulse, also the latch clear request |

## Verification
The bench first goes after wrapping. It loads a run that starts near the top of a page and a run of more than 256 bytes. A design that carried the index into the page address would corrupt the next page, and one that stopped at the page end would lose the tail bytes. It also checks that unloaded positions survive a partial write, which catches a design that commits the whole staging buffer. It closes sequences with no byte, with the protection verdict low, and during a running cycle. It changes the fast flag in the middle of a cycle. A design that sampled the flag late would run for the wrong number of clocks, and one that did not gate its inputs on busy would start a second cycle or store stray bytes.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } seq_state_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pwb_sdp_ram.sv
module pwb_sdp_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // one write port, one registered read port: maps onto a block RAM
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/pwb_loader.sv
module pwb_loader #(
  parameter int DATA_W  = 8,
  parameter int IDX_W   = 8,
  parameter int PAGE_AW = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic [IDX_W-1:0]   start_idx,
  input  logic [PAGE_AW-1:0] page_in,
  input  logic               take,
  input  logic [DATA_W-1:0]  data_in,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [DATA_W-1:0]  rd_data,
  output logic               rd_valid,
  output logic [PAGE_AW-1:0] page_q,
  output logic               got_byte
);

  localparam int SLOTS = 1 << IDX_W;

  logic [IDX_W-1:0] idx_q;
  logic [SLOTS-1:0] valid_q;
  logic             buf_we;

  assign buf_we = take && !clear;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q    <= '0;
      valid_q  <= '0;
      page_q   <= '0;
      got_byte <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= valid_q[rd_idx];
      if (clear) begin
        idx_q    <= start_idx;
        page_q   <= page_in;
        valid_q  <= '0;
        got_byte <= 1'b0;
      end else if (take) begin
        idx_q          <= idx_q + 1'b1;   // wraps inside the page
        valid_q[idx_q] <= 1'b1;
        got_byte       <= 1'b1;
      end
    end
  end

  pwb_sdp_ram #(
    .DATA_W(DATA_W),
    .ADDR_W(IDX_W)
  ) u_stage (
    .clk  (clk),
    .we   (buf_we),
    .waddr(idx_q),
    .wdata(data_in),
    .raddr(rd_idx),
    .rdata(rd_data)
  );

endmodule

// File: rtl/pwb_sequencer.sv
module pwb_sequencer
  import pwb_pkg::*;
#(
  parameter int IDX_W       = 8,
  parameter int STD_CYCLES  = 600,
  parameter int FAST_CYCLES = 300
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_start,
  input  logic             seq_end,
  input  logic             accept,
  input  logic             fast_mode,
  input  logic             got_byte,
  output logic             load_clear,
  output logic             load_open,
  output logic [IDX_W-1:0] commit_idx,
  output logic [IDX_W-1:0] commit_wr_idx,
  output logic             commit_wr,
  output logic             busy,
  output logic             done
);

  localparam int MAX_CYC = max_int(STD_CYCLES, FAST_CYCLES);
  localparam int TMR_W   = $clog2(MAX_CYC);

  seq_state_e       state_q;
  logic [TMR_W-1:0] timer_q;
  logic             copy_q;

  assign load_clear = load_start && (state_q != ST_PROG);
  assign load_open  = (state_q == ST_LOAD) && !load_start && !seq_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      timer_q       <= '0;
      copy_q        <= 1'b0;
      commit_idx    <= '0;
      commit_wr_idx <= '0;
      commit_wr     <= 1'b0;
      busy          <= 1'b0;
      done          <= 1'b0;
    end else begin
      done          <= 1'b0;
      commit_wr     <= copy_q;
      commit_wr_idx <= commit_idx;
      case (state_q)
        ST_IDLE: begin
          if (load_start) state_q <= ST_LOAD;
        end
        ST_LOAD: begin
          if (load_start) begin
            state_q <= ST_LOAD;
          end else if (seq_end) begin
            if (got_byte && accept) begin
              state_q    <= ST_PROG;
              busy       <= 1'b1;
              timer_q    <= fast_mode ? TMR_W'(FAST_CYCLES - 1) : TMR_W'(STD_CYCLES - 1);
              commit_idx <= '0;
              copy_q     <= 1'b1;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_PROG: begin
          if (copy_q) begin
            commit_idx <= commit_idx + 1'b1;
            if (&commit_idx) copy_q <= 1'b0;
          end
          if (timer_q == '0) begin
            state_q <= ST_IDLE;
            busy    <= 1'b0;
            done    <= 1'b1;
          end else begin
            timer_q <= timer_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/page_write_ctrl.sv
module page_write_ctrl #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 10,
  parameter int IDX_W       = 8,
  parameter int STD_CYCLES  = 600,
  parameter int FAST_CYCLES = 300
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              byte_strobe,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              seq_end,
  input  logic              accept,
  input  logic              fast_mode,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              done
);

  localparam int PAGE_AW = ADDR_W - IDX_W;

  logic               load_clear;
  logic               load_open;
  logic               take;
  logic               got_byte;
  logic [IDX_W-1:0]   commit_idx;
  logic [IDX_W-1:0]   commit_wr_idx;
  logic               commit_wr;
  logic [DATA_W-1:0]  stage_data;
  logic               stage_valid;
  logic [PAGE_AW-1:0] page_q;
  logic               arr_we;
  logic [ADDR_W-1:0]  arr_waddr;

  assign take      = byte_strobe && load_open;
  assign arr_we    = commit_wr && stage_valid;
  assign arr_waddr = {page_q, commit_wr_idx};

  pwb_sequencer #(
    .IDX_W      (IDX_W),
    .STD_CYCLES (STD_CYCLES),
    .FAST_CYCLES(FAST_CYCLES)
  ) u_seq (
    .clk          (clk),
    .rst          (rst),
    .load_start   (load_start),
    .seq_end      (seq_end),
    .accept       (accept),
    .fast_mode    (fast_mode),
    .got_byte     (got_byte),
    .load_clear   (load_clear),
    .load_open    (load_open),
    .commit_idx   (commit_idx),
    .commit_wr_idx(commit_wr_idx),
    .commit_wr    (commit_wr),
    .busy         (busy),
    .done         (done)
  );

  pwb_loader #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W),
    .PAGE_AW(PAGE_AW)
  ) u_load (
    .clk      (clk),
    .rst      (rst),
    .clear    (load_clear),
    .start_idx(start_addr[IDX_W-1:0]),
    .page_in  (start_addr[ADDR_W-1:IDX_W]),
    .take     (take),
    .data_in  (byte_data),
    .rd_idx   (commit_idx),
    .rd_data  (stage_data),
    .rd_valid (stage_valid),
    .page_q   (page_q),
    .got_byte (got_byte)
  );

  pwb_sdp_ram #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_array (
    .clk  (clk),
    .we   (arr_we),
    .waddr(arr_waddr),
    .wdata(stage_data),
    .raddr(rd_addr),
    .rdata(rd_data)
  );

endmodule

// File: rtl/pwc_checker.sv
module pwc_checker #(
  parameter int STD_CYCLES  = 600,
  parameter int FAST_CYCLES = 300
) (
  input logic clk,
  input logic rst,
  input logic seq_end,
  input logic accept,
  input logic busy,
  input logic done
);

  localparam int LONGEST = (STD_CYCLES > FAST_CYCLES) ? STD_CYCLES : FAST_CYCLES;

  int unsigned busy_cnt;

  always_ff @(posedge clk) begin
    if (rst) busy_cnt <= 0;
    else if (busy) busy_cnt <= busy_cnt + 1;
    else busy_cnt <= 0;
  end

  AST_START_NEEDS_CLOSE: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(seq_end) && $past(accept))); // R5

  AST_CYCLE_LENGTH: assert property (@(posedge clk) disable iff (rst)
    done |-> (busy_cnt == STD_CYCLES || busy_cnt == FAST_CYCLES)); // R6

  AST_CYCLE_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy |-> (busy_cnt < LONGEST)); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7

  AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done); // R7

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy) && !busy)); // R7

endmodule

bind page_write_ctrl pwc_checker #(
  .STD_CYCLES (STD_CYCLES),
  .FAST_CYCLES(FAST_CYCLES)
) u_pwc_checker (
  .clk    (clk),
  .rst    (rst),
  .seq_end(seq_end),
  .accept (accept),
  .busy   (busy),
  .done   (done)
);

// File: tb/page_write_ctrl_tb.sv
module page_write_ctrl_tb;

  localparam int STD_N  = 600;
  localparam int FAST_N = 300;
  localparam int DEPTH  = 1024;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load_start = 1'b0;
  logic [9:0] start_addr = '0;
  logic       byte_strobe = 1'b0;
  logic [7:0] byte_data = '0;
  logic       seq_end = 1'b0;
  logic       accept = 1'b1;
  logic       fast_mode = 1'b0;
  logic [9:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       busy;
  logic       done;

  int total = 0;
  int bad = 0;
  logic [7:0] exp_mem [DEPTH];

  always #4 clk = ~clk;

  page_write_ctrl #(
    .DATA_W(8), .ADDR_W(10), .IDX_W(8),
    .STD_CYCLES(STD_N), .FAST_CYCLES(FAST_N)
  ) u_dut (
    .clk(clk), .rst(rst), .load_start(load_start), .start_addr(start_addr),
    .byte_strobe(byte_strobe), .byte_data(byte_data), .seq_end(seq_end),
    .accept(accept), .fast_mode(fast_mode), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy), .done(done)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed + i * 13) & 255);
  endfunction

  // counts busy clocks; on return done has been checked
  task automatic wait_cycle(input string req, output int blen);
    blen = 0;
    while (busy && blen < 5000) begin
      blen++;
      tick();
    end
    chk(done == 1'b1, "R7 done on first idle clock", int'(done), 1);
    tick();
    chk(done == 1'b0, "R7 done lasts one clock", int'(done), 0);
  endtask

  task automatic run_write(input int addr, input int nbytes, input int seed,
                           input bit fast, input bit acc, input bit expect_go,
                           input string req, output int blen);
    logic [7:0] lb [256];
    bit         lv [256];
    int         idx;
    for (int j = 0; j < 256; j++) begin lb[j] = '0; lv[j] = 1'b0; end
    idx = addr & 255;
    load_start = 1'b1; start_addr = 10'(addr);
    tick();
    load_start = 1'b0;
    for (int i = 0; i < nbytes; i++) begin
      byte_strobe = 1'b1; byte_data = pat(seed, i);
      lb[idx] = pat(seed, i); lv[idx] = 1'b1;
      idx = (idx + 1) & 255;
      tick();
    end
    byte_strobe = 1'b0;
    seq_end = 1'b1; accept = acc; fast_mode = fast;
    tick();
    seq_end = 1'b0; accept = 1'b1;
    blen = 0;
    if (expect_go) begin
      chk(busy == 1'b1, {req, " busy rises"}, int'(busy), 1);
      wait_cycle(req, blen);
      for (int j = 0; j < 256; j++)
        if (lv[j]) exp_mem[(addr & ~255) + j] = lb[j];
    end else begin
      repeat (10) tick();
      chk(busy == 1'b0 && done == 1'b0, {req, " no cycle"}, int'(busy), 0);
    end
  endtask

  task automatic verify(input int lo, input int hi, input string req);
    for (int a = lo; a < hi; a++) begin
      rd_addr = 10'(a);
      tick();
      chk(rd_data == exp_mem[a], req, int'(rd_data), int'(exp_mem[a]));
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) tick();
    chk(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
    chk(done == 1'b0, "R1 done in reset", int'(done), 0);
    rst = 1'b0;
    tick();
    chk(busy == 1'b0 && done == 1'b0, "R1 idle after reset", int'(busy), 0);
  endtask

  task automatic t_fill();
    int bl;
    for (int p = 0; p < 4; p++) begin
      run_write(p * 256, 256, p * 41 + 7, 1'b0, 1'b1, 1'b1, "R2 fill", bl);
      chk(bl == STD_N, "R6 standard length", bl, STD_N);
    end
    verify(0, DEPTH, "R9 R2 full fill readback");
  endtask

  task automatic t_wrap_partial();
    int bl;
    run_write(256 + 250, 10, 99, 1'b1, 1'b1, 1'b1, "R3 wrap", bl);
    chk(bl == FAST_N, "R6 fast length", bl, FAST_N);
    verify(256, 512, "R3 R4 wrapped partial page");
    verify(512, 768, "R3 next page untouched");
  endtask

  task automatic t_overflow();
    int bl;
    run_write(512 + 5, 260, 200, 1'b0, 1'b1, 1'b1, "R3 overflow", bl);
    chk(bl == STD_N, "R6 standard length overflow", bl, STD_N);
    verify(256, 768, "R3 overflow replaces earlier bytes");
  endtask

  task automatic t_discard();
    int bl;
    run_write(768, 0, 1, 1'b0, 1'b1, 1'b0, "R5 empty sequence", bl);
    run_write(768 + 3, 6, 77, 1'b0, 1'b0, 1'b0, "R5 rejected by accept", bl);
    verify(768, 1024, "R5 array unchanged after drop");
  endtask

  task automatic t_busy_ignore();
    int bl;
    load_start = 1'b1; start_addr = 10'(768 + 16);
    tick();
    load_start = 1'b0;
    for (int i = 0; i < 4; i++) begin
      byte_strobe = 1'b1; byte_data = pat(5, i);
      exp_mem[768 + 16 + i] = pat(5, i);
      tick();
    end
    byte_strobe = 1'b0;
    seq_end = 1'b1; fast_mode = 1'b0;
    tick();
    seq_end = 1'b0;
    bl = 0;
    // commands while busy, plus a fast flag change
    fast_mode = 1'b1;
    load_start = 1'b1; start_addr = 10'd0;
    if (busy) bl++;
    tick();
    load_start = 1'b0;
    for (int i = 0; i < 3; i++) begin
      byte_strobe = 1'b1; byte_data = 8'hEE;
      if (busy) bl++;
      tick();
    end
    byte_strobe = 1'b0;
    seq_end = 1'b1;
    if (busy) bl++;
    tick();
    seq_end = 1'b0;
    while (busy && bl < 5000) begin
      bl++;
      tick();
    end
    chk(done == 1'b1, "R7 done after busy-ignore cycle", int'(done), 1);
    chk(bl == STD_N, "R6 fast flag change mid-cycle ignored", bl, STD_N);
    fast_mode = 1'b0;
    repeat (20) tick();
    chk(busy == 1'b0, "R8 no second cycle", int'(busy), 0);
    verify(0, 256, "R8 no stray bytes in page 0");
    verify(768, 1024, "R8 R4 page 3 after busy-time commands");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_fill();
    t_wrap_partial();
    t_overflow();
    t_discard();
    t_busy_ignore();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule